// File: doc/BRIEF.md
# Auxiliary and Power Control Registers

This block holds two special-function registers of an 8051-style microcontroller and the small amount of logic they steer. The CPU reaches both registers over a simple SFR bus: an address, a write strobe and write data, with registered read data. The auxiliary register carries one control bit, `ale_off`. When it is set, the address-latch-enable pulse train is held low while the core runs from internal code. The gate opens again by itself whenever the core signals external program or data activity, and it closes once that activity ends.

The power control register holds four things: a baud-doubling bit for the serial port, two free user flags, the idle and power-down request bits, and a power-off flag. Hardware sets the power-off flag only on a power-on reset. A warm reset leaves it alone. Software clears the flag, so that after a later reset firmware can tell a cold boot from a warm one. A wake-up input clears both sleep requests, and a pending power-down request masks the idle request.

Top module: `auxpwr_ctl`

## Requirements
- R1: The auxiliary register answers at SFR address 0x8E. Bit 0 is `ale_off` and can be read and written. Bits 7..1 read as 0.
- R2: While `ale_off` is 0, `ale_out` equals `ale_raw` delayed by one clock.
- R3: While `ale_off` is 1 and `ext_access` is 1, `ale_out` equals `ale_raw` delayed by one clock.
- R4: While `ale_off` is 1 and `ext_access` is 0, `ale_out` is 0 on the next clock.
- R5: The power control register answers at SFR address 0x87 with this layout: bit7 baud double, bit4 power-off flag, bit3 and bit2 user flags, bit1 power-down, bit0 idle. Bits 6 and 5 read 0, and writes to them are ignored. `sfr_rdata` is registered: it shows, one clock after the address, the value held before any write in that same cycle.
- R6: A power-on reset (`rst_por`, synchronous, active high, dominant over every other input) sets the power-off flag to 1 and clears every other bit. `sfr_rdata` and `ale_out` go to 0.
- R7: A warm reset (`rst_warm`) clears `ale_off`, baud double, both user flags, power-down and idle. It leaves the power-off flag unchanged.
- R8: The power-off flag changes only through a power-on reset or an SFR write to 0x87, which loads it from bit 4.
- R9: `baud_double` equals the baud-double bit.
- R10: `pd_req` equals the power-down bit. `idle_req` is 1 only when the idle bit is set and the power-down bit is clear.
- R11: `wake` clears the power-down and idle bits on the next clock. It wins over an SFR write in the same cycle.
- R12: The two user flags can be read and written and have no effect on any output other than `sfr_rdata`.
- R13: Writes to any other SFR address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_warm | input | 1 | Warm (software or pin) reset, synchronous, active high |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Registered SFR read data |
| ale_raw | input | 1 | Ungated ALE pulse train from the core |
| ext_access | input | 1 | High during external code fetch or external data access |
| wake | input | 1 | Wake-up event, clears the sleep requests |
| ale_out | output | 1 | Gated, registered ALE |
| baud_double | output | 1 | Serial baud doubling for modes 1 to 3 |
| pd_req | output | 1 | Power-down request |
| idle_req | output | 1 | Idle request |

## Verification
The assertions check four things on every cycle. The ALE gate's pass-or-hold rule. The retention of the power-off flag across warm resets and across cycles with no clearing write. Wake clearing both sleep bits. The zero reading of the unused bits, together with the mutual exclusion of the two sleep outputs. Some behaviours show only in the bench's scenarios, which run against a behavioural model: the exact register layout read back after writes, wake winning over a write in the same cycle, the contrast between power-on and warm reset, and the lack of side effects from the user flags and from foreign addresses.

// File: rtl/auxpwr_pkg.sv
package auxpwr_pkg;
  localparam int REG_W   = 8;
  // bit positions inside the power control register (software decodes these)
  localparam int PB_SMOD = 7;
  localparam int PB_POF  = 4;
  localparam int PB_GF1  = 3;
  localparam int PB_GF0  = 2;
  localparam int PB_PD   = 1;
  localparam int PB_IDL  = 0;
  localparam int AB_AO   = 0;

  typedef struct packed {
    logic smod;
    logic pof;
    logic gf1;
    logic gf0;
    logic pd;
    logic idl;
  } pwr_bits_t;

  function automatic logic [REG_W-1:0] pack_pwr(input pwr_bits_t b);
    logic [REG_W-1:0] v;
    v          = '0;
    v[PB_SMOD] = b.smod;
    v[PB_POF]  = b.pof;
    v[PB_GF1]  = b.gf1;
    v[PB_GF0]  = b.gf0;
    v[PB_PD]   = b.pd;
    v[PB_IDL]  = b.idl;
    return v;
  endfunction
endpackage

// File: rtl/auxpwr_aux_reg.sv
module auxpwr_aux_reg
  import auxpwr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] AUX_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_warm,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [REG_W-1:0]  sfr_wdata,
  output logic              ao_q
);
  logic hit;
  assign hit = sfr_wr && (sfr_addr == AUX_ADDR);

  always_ff @(posedge clk) begin
    if (rst_por || rst_warm) ao_q <= 1'b0;
    else if (hit)            ao_q <= sfr_wdata[AB_AO];
  end

  // R7
  aux_warm_clear_chk: assert property (@(posedge clk) disable iff (rst_por)
    rst_warm |=> !ao_q);
endmodule

// File: rtl/auxpwr_pwr_reg.sv
module auxpwr_pwr_reg
  import auxpwr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_warm,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [REG_W-1:0]  sfr_wdata,
  input  logic              wake,
  output pwr_bits_t         bits_q
);
  logic hit;
  assign hit = sfr_wr && (sfr_addr == PWR_ADDR);

  always_ff @(posedge clk) begin
    if (rst_por) begin
      bits_q     <= '0;
      bits_q.pof <= 1'b1;
    end else if (rst_warm) begin
      bits_q.smod <= 1'b0;
      bits_q.gf1  <= 1'b0;
      bits_q.gf0  <= 1'b0;
      bits_q.pd   <= 1'b0;
      bits_q.idl  <= 1'b0;
    end else begin
      if (hit) begin
        bits_q.smod <= sfr_wdata[PB_SMOD];
        bits_q.pof  <= sfr_wdata[PB_POF];
        bits_q.gf1  <= sfr_wdata[PB_GF1];
        bits_q.gf0  <= sfr_wdata[PB_GF0];
        bits_q.pd   <= sfr_wdata[PB_PD];
        bits_q.idl  <= sfr_wdata[PB_IDL];
      end
      if (wake) begin
        bits_q.pd  <= 1'b0;
        bits_q.idl <= 1'b0;
      end
    end
  end

  // R7
  pof_warm_keep_chk: assert property (@(posedge clk) disable iff (rst_por)
    rst_warm |=> (bits_q.pof == $past(bits_q.pof)) && !bits_q.pd && !bits_q.idl);
  // R8
  pof_sticky_chk: assert property (@(posedge clk) disable iff (rst_por)
    (bits_q.pof && !(hit && !rst_warm && !sfr_wdata[PB_POF])) |=> bits_q.pof);
  // R11
  wake_clear_chk: assert property (@(posedge clk) disable iff (rst_por)
    wake |=> !bits_q.pd && !bits_q.idl);
endmodule

// File: rtl/auxpwr_ale_gate.sv
module auxpwr_ale_gate (
  input  logic clk,
  input  logic rst_por,
  input  logic ale_raw,
  input  logic ext_access,
  input  logic ao,
  output logic ale_out
);
  logic open_gate;
  assign open_gate = !ao || ext_access;

  always_ff @(posedge clk) begin
    if (rst_por) ale_out <= 1'b0;
    else         ale_out <= ale_raw && open_gate;
  end

  // R4
  ale_held_chk: assert property (@(posedge clk) disable iff (rst_por)
    (ao && !ext_access) |=> !ale_out);
  // R2 R3
  ale_pass_chk: assert property (@(posedge clk) disable iff (rst_por)
    (!ao || ext_access) |=> (ale_out == $past(ale_raw)));
endmodule

// File: rtl/auxpwr_ctl.sv
module auxpwr_ctl
  import auxpwr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] AUX_ADDR = 8'h8E,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_warm,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [REG_W-1:0]  sfr_wdata,
  output logic [REG_W-1:0]  sfr_rdata,
  input  logic              ale_raw,
  input  logic              ext_access,
  input  logic              wake,
  output logic              ale_out,
  output logic              baud_double,
  output logic              pd_req,
  output logic              idle_req
);
  logic      ao_q;
  pwr_bits_t pbits;
  logic [REG_W-1:0] rd_next;

  auxpwr_aux_reg #(.ADDR_W(ADDR_W), .AUX_ADDR(AUX_ADDR)) u_aux (
    .clk(clk), .rst_por(rst_por), .rst_warm(rst_warm), .sfr_addr(sfr_addr),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .ao_q(ao_q));

  auxpwr_pwr_reg #(.ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR)) u_pwr (
    .clk(clk), .rst_por(rst_por), .rst_warm(rst_warm), .sfr_addr(sfr_addr),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .wake(wake), .bits_q(pbits));

  auxpwr_ale_gate u_gate (
    .clk(clk), .rst_por(rst_por), .ale_raw(ale_raw), .ext_access(ext_access),
    .ao(ao_q), .ale_out(ale_out));

  always_comb begin
    rd_next = '0;
    if (sfr_addr == PWR_ADDR)      rd_next = pack_pwr(pbits);
    else if (sfr_addr == AUX_ADDR) rd_next[AB_AO] = ao_q;
  end

  always_ff @(posedge clk) begin
    if (rst_por) sfr_rdata <= '0;
    else         sfr_rdata <= rd_next;
  end

  assign baud_double = pbits.smod;
  assign pd_req      = pbits.pd;
  assign idle_req    = pbits.idl && !pbits.pd;

  // R5
  pwr_unused_zero_chk: assert property (@(posedge clk) disable iff (rst_por)
    (sfr_addr == PWR_ADDR) |=> (sfr_rdata[6:5] == 2'b00));
  // R13
  foreign_read_zero_chk: assert property (@(posedge clk) disable iff (rst_por)
    (sfr_addr != PWR_ADDR && sfr_addr != AUX_ADDR) |=> (sfr_rdata == '0));
  // R10
  sleep_excl_chk: assert property (@(posedge clk) disable iff (rst_por)
    !(pd_req && idle_req));
endmodule

// File: tb/auxpwr_ctl_bench.sv
module auxpwr_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_por = 1'b1, rst_warm = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic       sfr_wr = 1'b0, ale_raw = 1'b0, ext_access = 1'b0, wake = 1'b0;
  logic [7:0] sfr_rdata;
  logic       ale_out, baud_double, pd_req, idle_req;

  int checks = 0, fails = 0;

  // behavioural reference state
  bit m_ao, m_smod, m_pof, m_gf1, m_gf0, m_pd, m_idl, m_ale;
  int m_rd;

  always #10 clk = ~clk; // 50 MHz

  auxpwr_ctl u_auxpwr_ctl (
    .clk(clk), .rst_por(rst_por), .rst_warm(rst_warm), .sfr_addr(sfr_addr),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ale_raw(ale_raw), .ext_access(ext_access), .wake(wake), .ale_out(ale_out),
    .baud_double(baud_double), .pd_req(pd_req), .idle_req(idle_req));

  function automatic int pwr_val();
    return (int'(m_smod) << 7) | (int'(m_pof) << 4) | (int'(m_gf1) << 3) |
           (int'(m_gf0) << 2) | (int'(m_pd) << 1) | int'(m_idl);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int rd;
    bit ale_n;
    if (sfr_addr == 8'h87)      rd = pwr_val();
    else if (sfr_addr == 8'h8E) rd = int'(m_ao);
    else                        rd = 0;
    ale_n = ale_raw && (!m_ao || ext_access);
    if (rst_por) begin
      m_ao = 0; m_smod = 0; m_pof = 1; m_gf1 = 0; m_gf0 = 0; m_pd = 0; m_idl = 0;
      m_rd = 0; m_ale = 0;
    end else begin
      m_rd = rd; m_ale = ale_n;
      if (rst_warm) begin
        m_ao = 0; m_smod = 0; m_gf1 = 0; m_gf0 = 0; m_pd = 0; m_idl = 0;
      end else begin
        if (sfr_wr && sfr_addr == 8'h8E) m_ao = sfr_wdata[0];
        if (sfr_wr && sfr_addr == 8'h87) begin
          m_smod = sfr_wdata[7]; m_pof = sfr_wdata[4]; m_gf1 = sfr_wdata[3];
          m_gf0 = sfr_wdata[2]; m_pd = sfr_wdata[1]; m_idl = sfr_wdata[0];
        end
        if (wake) begin m_pd = 0; m_idl = 0; end
      end
    end
  endtask

  // one clock: model updates on the edge, every output compared after it
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #1;
    chk(tag, "sfr_rdata", int'(sfr_rdata), m_rd);
    chk(tag, "ale_out", int'(ale_out), int'(m_ale));
    chk(tag, "baud_double", int'(baud_double), int'(m_smod));
    chk(tag, "pd_req", int'(pd_req), int'(m_pd));
    chk(tag, "idle_req", int'(idle_req), int'(m_idl && !m_pd));
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    step(tag);
    sfr_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    sfr_addr = a;
    step(tag);
    chk(tag, "readback", int'(sfr_rdata), exp);
  endtask

  task automatic ale_train(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      ale_raw = i[0];
      step(tag);
    end
    ale_raw = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R6"); step("R6"); step("R6");
    rst_por = 1'b0;
    rd(8'h87, 8'h10, "R6");
    rd(8'h8E, 8'h00, "R6");
    // R2: gate open with ale_off clear
    ale_train(6, "R2");
    // R1: aux register readback, upper bits zero
    wr(8'h8E, 8'hFF, "R1");
    rd(8'h8E, 8'h01, "R1");
    // R4: held off on internal code
    ext_access = 1'b0;
    ale_train(6, "R4");
    // R3: reopens during external access, closes after
    ext_access = 1'b1;
    ale_train(6, "R3");
    ext_access = 1'b0;
    ale_train(4, "R4");
    // R5 R9 R10: full write, unused bits ignored
    wr(8'h87, 8'hFF, "R5");
    rd(8'h87, 8'h9F, "R5");
    chk("R9", "baud_double", int'(baud_double), 1);
    chk("R10", "pd over idle", int'(idle_req), 0);
    wr(8'h87, 8'h01, "R10");
    chk("R10", "idle_req", int'(idle_req), 1);
    // R12: user flags only
    wr(8'h87, 8'h0C, "R12");
    rd(8'h87, 8'h0C, "R12");
    chk("R12", "no side effect", int'({baud_double, pd_req, idle_req}), 0);
    // R11: wake clears, and beats a write in the same cycle
    wr(8'h87, 8'h03, "R11");
    wake = 1'b1; step("R11"); wake = 1'b0;
    rd(8'h87, 8'h00, "R11");
    wake = 1'b1; wr(8'h87, 8'h93, "R11"); wake = 1'b0;
    rd(8'h87, 8'h90, "R11");
    // R7: warm reset keeps the set flag
    wr(8'h87, 8'h9F, "R7");
    rst_warm = 1'b1; step("R7"); rst_warm = 1'b0;
    rd(8'h87, 8'h10, "R7");
    rd(8'h8E, 8'h00, "R7");
    // R8: software clear survives warm reset, power-on sets again
    wr(8'h87, 8'h00, "R8");
    rst_warm = 1'b1; step("R8"); rst_warm = 1'b0;
    rd(8'h87, 8'h00, "R8");
    rst_por = 1'b1; step("R8"); rst_por = 1'b0;
    rd(8'h87, 8'h10, "R8");
    // R13: foreign address has no effect
    wr(8'h30, 8'hFF, "R13");
    rd(8'h30, 8'h00, "R13");
    rd(8'h87, 8'h10, "R13");
    rd(8'h8E, 8'h00, "R13");
    summary();
    $finish;
  end
endmodule